// File: doc/BRIEF.md
# FIFO-Drain Burst DMA Mover

This engine moves a block of 32-bit words from a memory-mapped FIFO port to ordinary memory. The source is a single register address that returns the next FIFO entry on every read, so the read master keeps that address fixed for the whole job. It issues only single-word reads. The read master is pipelined: it may have several reads in flight, limited by space in an internal staging buffer. The write master sends the words to incrementing destination addresses in multi-beat bursts, because external memory is much slower when written one word at a time.

Software-style control is plain. Place the source address, destination address and byte count on the command pins and pulse start for one cycle. Busy is high while the job runs, and done pulses once when the final write beat has gone out.

Both masters follow memory-mapped back-pressure. A request (read or write) counts as accepted on a clock edge where waitrequest is low. While waitrequest is high, the master holds the request, the address, the burst count and the write data unchanged. Read data has no back-pressure: the engine always takes a word whenever readdatavalid is high. It never requests more reads than the staging buffer can absorb.

Top module: `fifo_burst_dma`

## Requirements
- R1: During a transfer every read request carries the source address latched at start. The address never changes between reads.
- R2: Each read is a single-word request. Exactly length/4 reads are accepted per transfer, and the words are taken in the order readdatavalid presents them.
- R3: Each write burst has burstcount = min(MAX_BURST, words still unwritten). Its address is destination + 4 × (words written before it). Beat data follows read order.
- R4: While waitrequest is high on an asserted request, the next cycle still shows that request with the same address. On the write side, burstcount and write data are also unchanged.
- R5: A write burst begins only after all of its words have been returned by the read side.
- R6: Reads accepted minus write beats accepted never exceeds STAGE_DEPTH (16 by default). The staging buffer never overflows.
- R7: Busy rises in the cycle after an accepted start. Done is a one-cycle pulse in the cycle after the final write beat is accepted, and busy is low from that same cycle.
- R8: A start with a word count of zero gives a done pulse in the next cycle. It issues no read or write, and busy stays low.
- R9: Start and the command pins are ignored while busy. The running transfer's addresses, length and single done pulse are unaffected.
- R10: The length is in bytes, with bits [1:0] ignored. Lengths up to 2048 bytes (512 words) are supported.
- R11: After reset, busy, done, read and write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_src_addr | input | 32 | Fixed FIFO source address |
| cmd_dst_addr | input | 32 | First destination byte address |
| cmd_len_bytes | input | 12 | Transfer length in bytes |
| cmd_start | input | 1 | One-cycle start request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_address | output | 32 | Read master address |
| rd_read | output | 1 | Read request |
| rd_waitrequest | input | 1 | Read back-pressure |
| rd_readdata | input | 32 | Returned read word |
| rd_readdatavalid | input | 1 | Read word valid |
| wr_address | output | 32 | Burst start address |
| wr_write | output | 1 | Write request |
| wr_writedata | output | 32 | Write beat data |
| wr_burstcount | output | 4 | Beats in current burst |
| wr_waitrequest | input | 1 | Write back-pressure |

## Verification
A lost or duplicated entry in the staging buffer shows up at the first write beat that uses it. The beat data then breaks the read-order sequence within a burst of the fault. A wrong remaining-word count appears at the next burst start, either as a bad burstcount or address, or as an early or missing done. A mis-tracked in-flight read counter shows as the read side running ahead of the write side by more than the buffer depth. The outcome can also be a hang, which the per-transfer timeout reports.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FILL  = 2'd1,
    WS_BURST = 2'd2
  } wr_state_e;
endpackage

// File: rtl/fbd_stage_buf.sv
module fbd_stage_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = mem[rptr];

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)) || pop);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/fbd_read_ctl.sv
module fbd_read_ctl #(
  parameter int ADDR_W = 32,
  parameter int WCNT_W = 10,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [WCNT_W-1:0] nwords,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic              rd_waitrequest,
  input  logic              rd_readdatavalid,
  output logic              rd_read,
  output logic [ADDR_W-1:0] rd_address
);
  logic [WCNT_W-1:0] to_issue;
  logic [CNT_W-1:0]  in_flight;
  logic [CNT_W:0]    occupancy;
  logic              accept;

  assign occupancy = {1'b0, buf_count} + {1'b0, in_flight};
  assign rd_read   = (to_issue != '0) && (occupancy < (CNT_W + 1)'(DEPTH));
  assign accept    = rd_read && !rd_waitrequest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_issue   <= '0;
      in_flight  <= '0;
      rd_address <= '0;
    end else begin
      if (go) begin
        to_issue   <= nwords;
        rd_address <= src_addr;
      end else if (accept) begin
        to_issue <= to_issue - 1'b1;
      end
      in_flight <= in_flight + CNT_W'(accept) - CNT_W'(rd_readdatavalid);
    end
  end

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_read && rd_waitrequest |=> rd_read && $stable(rd_address));
  assert_rd_fixed_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_read && $past(rd_read) |-> rd_address == $past(rd_address));
  assert_rd_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= (CNT_W + 1)'(DEPTH));
endmodule

// File: rtl/fbd_write_ctl.sv
module fbd_write_ctl
  import fbd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WCNT_W    = 10,
  parameter int MAX_BURST = 8,
  parameter int BC_W      = $clog2(MAX_BURST + 1),
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [WCNT_W-1:0] nwords,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic [DATA_W-1:0] buf_head,
  input  logic              wr_waitrequest,
  output logic              buf_pop,
  output logic              last_beat,
  output logic              wr_write,
  output logic [ADDR_W-1:0] wr_address,
  output logic [DATA_W-1:0] wr_writedata,
  output logic [BC_W-1:0]   wr_burstcount
);
  wr_state_e         state;
  logic [WCNT_W-1:0] remain;
  logic [BC_W-1:0]   beats_left;
  logic [BC_W-1:0]   next_len;
  logic              accept;

  assign next_len      = (remain < WCNT_W'(MAX_BURST)) ? BC_W'(remain) : BC_W'(MAX_BURST);
  assign wr_write      = (state == WS_BURST);
  assign accept        = wr_write && !wr_waitrequest;
  assign buf_pop       = accept;
  assign last_beat     = accept && (remain == WCNT_W'(1));
  assign wr_writedata  = buf_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= WS_IDLE;
      remain        <= '0;
      beats_left    <= '0;
      wr_address    <= '0;
      wr_burstcount <= '0;
    end else begin
      case (state)
        WS_IDLE: if (go) begin
          wr_address <= dst_addr;
          remain     <= nwords;
          state      <= WS_FILL;
        end
        WS_FILL: if (buf_count >= CNT_W'(next_len)) begin
          wr_burstcount <= next_len;
          beats_left    <= next_len;
          state         <= WS_BURST;
        end
        WS_BURST: if (accept) begin
          remain     <= remain - 1'b1;
          beats_left <= beats_left - 1'b1;
          if (beats_left == BC_W'(1)) begin
            wr_address <= wr_address + ADDR_W'({wr_burstcount, 2'b00});
            state      <= (remain == WCNT_W'(1)) ? WS_IDLE : WS_FILL;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_write && wr_waitrequest |=> wr_write && $stable(wr_address)
      && $stable(wr_burstcount) && $stable(wr_writedata));
  assert_wr_blen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_write |-> (wr_burstcount != '0) && (wr_burstcount <= BC_W'(MAX_BURST)));
  assert_wr_data_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_write |-> buf_count >= CNT_W'(beats_left));
endmodule

// File: rtl/fifo_burst_dma.sv
module fifo_burst_dma #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 12,
  parameter int MAX_BURST   = 8,
  parameter int STAGE_DEPTH = 16,
  localparam int WCNT_W     = LEN_W - 2,
  localparam int CNT_W      = $clog2(STAGE_DEPTH + 1),
  localparam int BC_W       = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_src_addr,
  input  logic [ADDR_W-1:0] cmd_dst_addr,
  input  logic [LEN_W-1:0]  cmd_len_bytes,
  input  logic              cmd_start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] rd_address,
  output logic              rd_read,
  input  logic              rd_waitrequest,
  input  logic [DATA_W-1:0] rd_readdata,
  input  logic              rd_readdatavalid,
  output logic [ADDR_W-1:0] wr_address,
  output logic              wr_write,
  output logic [DATA_W-1:0] wr_writedata,
  output logic [BC_W-1:0]   wr_burstcount,
  input  logic              wr_waitrequest
);
  logic [WCNT_W-1:0] req_words;
  logic              take, go, last_beat, buf_pop;
  logic [CNT_W-1:0]  buf_count;
  logic [DATA_W-1:0] buf_head;
  logic              unused_len_lsbs;

  assign req_words       = cmd_len_bytes[LEN_W-1:2];
  assign unused_len_lsbs = ^cmd_len_bytes[1:0];
  assign take            = cmd_start && !busy;
  assign go              = take && (req_words != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      if (go)             busy <= 1'b1;
      else if (last_beat) busy <= 1'b0;
      done <= last_beat || (take && (req_words == '0));
    end
  end

  fbd_read_ctl #(.ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .DEPTH(STAGE_DEPTH), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .src_addr(cmd_src_addr), .nwords(req_words),
    .buf_count(buf_count), .rd_waitrequest(rd_waitrequest),
    .rd_readdatavalid(rd_readdatavalid), .rd_read(rd_read), .rd_address(rd_address));

  fbd_stage_buf #(.DATA_W(DATA_W), .DEPTH(STAGE_DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(rd_readdatavalid), .push_data(rd_readdata),
    .pop(buf_pop), .head(buf_head), .count(buf_count));

  fbd_write_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W),
                  .MAX_BURST(MAX_BURST), .BC_W(BC_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(go), .dst_addr(cmd_dst_addr), .nwords(req_words),
    .buf_count(buf_count), .buf_head(buf_head), .wr_waitrequest(wr_waitrequest),
    .buf_pop(buf_pop), .last_beat(last_beat), .wr_write(wr_write),
    .wr_address(wr_address), .wr_writedata(wr_writedata), .wr_burstcount(wr_burstcount));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_write);
endmodule

// File: tb/fifo_burst_dma_bench.sv
`timescale 1ns/1ps
module fifo_burst_dma_bench;
  localparam int MAXB  = 8;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmd_src_addr = '0, cmd_dst_addr = '0;
  logic [11:0] cmd_len_bytes = '0;
  logic        cmd_start = 1'b0;
  logic        busy, done;
  logic [31:0] rd_address, rd_readdata = '0;
  logic        rd_read, rd_waitrequest = 1'b0, rd_readdatavalid = 1'b0;
  logic [31:0] wr_address, wr_writedata;
  logic        wr_write, wr_waitrequest = 1'b0;
  logic [3:0]  wr_burstcount;

  always #2 clk = ~clk;

  fifo_burst_dma u_fifo_burst_dma (
    .clk(clk), .rst_n(rst_n), .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
    .cmd_len_bytes(cmd_len_bytes), .cmd_start(cmd_start), .busy(busy), .done(done),
    .rd_address(rd_address), .rd_read(rd_read), .rd_waitrequest(rd_waitrequest),
    .rd_readdata(rd_readdata), .rd_readdatavalid(rd_readdatavalid),
    .wr_address(wr_address), .wr_write(wr_write), .wr_writedata(wr_writedata),
    .wr_burstcount(wr_burstcount), .wr_waitrequest(wr_waitrequest));

  int checks = 0, fails = 0;
  int tid = 0, cyc = 0;
  int exp_words = 0, rd_acc = 0, rd_ret = 0, wr_cnt = 0, bl_left = 0;
  int done_cnt = 0, done_cyc = -1, last_cyc = -1;
  int rd_stall = 0, wr_stall = 0;
  logic [31:0] exp_src = '0, exp_dst = '0;
  logic [31:0] rq_data [64];
  int          rq_due  [64];
  int          rq_head = 0, rq_tail = 0, rq_cnt = 0, last_due = 0;

  function automatic logic [31:0] gen(input int t, input int k);
    return (32'(t) * 32'h9E3779B9) ^ (32'(k) * 32'h00010003) ^ 32'h5A5A0000;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bus slave models, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rd_waitrequest   = 1'b0;
      rd_readdatavalid = 1'b0;
      wr_waitrequest   = 1'b0;
    end else begin
      wr_waitrequest = int'($urandom % 100) < wr_stall;
      if (wr_write && !wr_waitrequest) begin
        if (bl_left == 0) begin
          chk(wr_address == exp_dst + 32'(4 * wr_cnt), "R3 burst address", wr_address, exp_dst + 32'(4 * wr_cnt));
          chk(int'(wr_burstcount) == min_i(MAXB, exp_words - wr_cnt), "R3 burstcount",
              32'(wr_burstcount), 32'(min_i(MAXB, exp_words - wr_cnt)));
          chk(rd_ret >= wr_cnt + int'(wr_burstcount), "R5 data buffered before burst",
              32'(rd_ret), 32'(wr_cnt + int'(wr_burstcount)));
          bl_left = int'(wr_burstcount);
        end
        chk(wr_writedata == gen(tid, wr_cnt), "R3 beat data order", wr_writedata, gen(tid, wr_cnt));
        wr_cnt++;
        bl_left--;
        if (wr_cnt == exp_words) last_cyc = cyc;
      end
      rd_waitrequest = int'($urandom % 100) < rd_stall;
      if (rd_read && !rd_waitrequest) begin
        chk(rd_address == exp_src, "R1 fixed read address", rd_address, exp_src);
        chk(rd_acc - wr_cnt < DEPTH, "R6 read lead within depth", 32'(rd_acc - wr_cnt), 32'(DEPTH));
        last_due = (cyc + 1 + int'($urandom % 3) > last_due) ? cyc + 1 + int'($urandom % 3) : last_due + 1;
        rq_data[rq_tail] = gen(tid, rd_acc);
        rq_due[rq_tail]  = last_due;
        rq_tail = (rq_tail + 1) % 64;
        rq_cnt++;
        rd_acc++;
      end
      if (rq_cnt > 0 && rq_due[rq_head] <= cyc) begin
        rd_readdatavalid = 1'b1;
        rd_readdata      = rq_data[rq_head];
        rq_head = (rq_head + 1) % 64;
        rq_cnt--;
        rd_ret++;
      end else begin
        rd_readdatavalid = 1'b0;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input logic [11:0] lb,
                          input int rs, input int ws, input bit poke);
    int n;
    bit busy_ok;
    @(negedge clk);
    tid++;
    exp_src = s; exp_dst = d; exp_words = int'(lb >> 2);
    rd_acc = 0; rd_ret = 0; wr_cnt = 0; bl_left = 0;
    done_cnt = 0; done_cyc = -1; last_cyc = -1;
    rd_stall = rs; wr_stall = ws;
    cmd_src_addr = s; cmd_dst_addr = d; cmd_len_bytes = lb; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (exp_words == 0) begin
      chk(done == 1'b1, "R8 zero length done next cycle", 32'(done), 32'd1);
      chk(busy == 1'b0, "R8 zero length busy low", 32'(busy), 32'd0);
      repeat (8) @(negedge clk);
      chk(rd_acc == 0 && wr_cnt == 0, "R8 no bus traffic", 32'(rd_acc + wr_cnt), 32'd0);
      chk(done_cnt == 1, "R8 single done", 32'(done_cnt), 32'd1);
    end else begin
      chk(busy == 1'b1, "R7 busy after start", 32'(busy), 32'd1);
      busy_ok = 1'b1;
      n = 0;
      if (poke) begin
        repeat (4) @(negedge clk);
        cmd_src_addr = s ^ 32'hFFFF_0000; cmd_dst_addr = d + 32'h100;
        cmd_len_bytes = 12'd8; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
      end
      while (!done && n < 20000) begin
        if (!busy) busy_ok = 1'b0;
        @(negedge clk);
        n++;
      end
      chk(n < 20000, "R7 transfer completes", 32'(n), 32'd20000);
      chk(busy_ok, "R7 busy held until done", 32'(busy_ok), 32'd1);
      chk(busy == 1'b0, "R7 busy low with done", 32'(busy), 32'd0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
      chk(done_cnt == 1, poke ? "R9 single done despite extra start" : "R7 single done",
          32'(done_cnt), 32'd1);
      chk(done_cyc == last_cyc + 1, "R7 done after final beat", 32'(done_cyc), 32'(last_cyc + 1));
      chk(wr_cnt == exp_words, "R10 words written", 32'(wr_cnt), 32'(exp_words));
      chk(rd_acc == exp_words && rd_ret == exp_words, "R2 single-word reads count",
          32'(rd_acc), 32'(exp_words));
      if (poke) chk(rd_acc == exp_words, "R9 length unchanged by ignored start", 32'(rd_acc), 32'(exp_words));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!busy && !done, "R11 reset idle", {30'd0, busy, done}, 32'd0);
    chk(!rd_read && !wr_write, "R11 reset no requests", {30'd0, rd_read, wr_write}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_read && !wr_write, "R11 idle after reset", {29'd0, busy, rd_read, wr_write}, 32'd0);

    run_xfer(32'h1000_0040, 32'h2000_0000, 12'd4,    0,  0,  1'b0); // single word
    run_xfer(32'h1000_0040, 32'h2000_1000, 12'd32,   20, 20, 1'b0); // exactly one burst
    run_xfer(32'h1000_0044, 32'h2000_2000, 12'd36,   30, 30, 1'b0); // burst plus one
    run_xfer(32'h1000_0048, 32'h2000_3000, 12'd0,    0,  0,  1'b0); // zero length R8
    run_xfer(32'h1000_0048, 32'h2000_4000, 12'd3,    0,  0,  1'b0); // R10 low bits only -> zero
    run_xfer(32'h1000_004C, 32'h2000_5000, 12'd23,   10, 50, 1'b0); // R10 unaligned, 5 words
    run_xfer(32'h1000_0050, 32'h3000_0000, 12'd2048, 25, 25, 1'b0); // R10 maximum length
    run_xfer(32'h1000_0054, 32'h3000_8000, 12'd400,  10, 10, 1'b1); // R9 start while busy
    run_xfer(32'h1000_0058, 32'h3001_0000, 12'd256,  0,  80, 1'b0); // R6 slow writer
    run_xfer(32'h1000_005C, 32'h3002_0000, 12'd256,  80, 0,  1'b0); // slow reader
    for (int i = 0; i < 16; i++) begin
      run_xfer($urandom & 32'hFFFF_FFFC, $urandom & 32'h0FFF_FFFC,
               12'($urandom % 2049), int'($urandom % 60), int'($urandom % 60), 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule